// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one output cell of a programmable logic array. A data bit, taken either from the sum-of-products allocator or straight from the pad input, passes through a polarity inverter. It then either goes straight to the output or is held in a storage bit. The storage bit can act as an edge-triggered load register, an edge-triggered toggle register or a level-sensitive transparent latch. Its clock comes from a selector with eight sources: the block clocks, a shared term clock and its inverse, and a per-cell term clock and its inverse.

Everything runs in one system clock domain, `clk_i`. Each selectable clock source is sampled on `clk_i`. An active edge is a cycle in which the selected source reads 1 after reading 0 in the previous cycle. Clear and set controls override the output in the same cycle and are stored at the next `clk_i` edge. The clear comes from one of two initialization terms, picked by a configuration bit.

Top module: `macrocell_cell`

## Requirements
- R1: While `rst_ni` is low the stored bit and the edge detector are cleared at once, without waiting for a clock edge, so `q_o` reads 0 in every registered mode.
- R2: With `cfg_mode_i` = 2'b00 (combinational), `q_o` equals the selected data source XOR `cfg_pol_i` in the same cycle, and clear and set have no effect on it.
- R3: With `cfg_mode_i` = 2'b01 (load register), an active edge with `ce_i` high stores the polarity-adjusted data, and `q_o` shows it right after that `clk_i` edge.
- R4: With `cfg_mode_i` = 2'b10 (toggle register), an active edge with `ce_i` high inverts the stored bit when the polarity-adjusted data is 1 and keeps it when the data is 0.
- R5: With `cfg_mode_i` = 2'b11 (latch), `q_o` follows the polarity-adjusted data while the selected clock reads 1 and `ce_i` is high. Otherwise it holds the last value it passed.
- R6: `cfg_clk_sel_i` picks the clock source as follows. Codes 0 to 3 select `blk_clk_i[0]` to `blk_clk_i[3]`. Code 4 selects `shr_clk_i`, code 5 `ind_clk_i`, code 6 the inverse of `ind_clk_i`, and code 7 the inverse of `shr_clk_i`.
- R7: In the load and toggle modes the stored bit changes only on an active edge with `ce_i` high. A selected clock that stays at 1, or an edge seen while `ce_i` is low, leaves it unchanged.
- R8: In a registered mode an active clear forces `q_o` to 0 in the same cycle and stores 0 at the next edge. Clear wins over `preset_i`.
- R9: In a registered mode `preset_i` without a clear forces `q_o` to 1 in the same cycle and stores 1 at the next edge.
- R10: `cfg_init_sel_i` = 0 takes the clear from `shr_init_i`, and `cfg_init_sel_i` = 1 takes it from `ind_init_i`. The term that is not selected has no effect.
- R11: `cfg_dir_i` = 1 takes the data from `io_i`, and `cfg_dir_i` = 0 takes it from `alloc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all clock sources |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| cfg_mode_i | input | 2 | 00 combinational, 01 load, 10 toggle, 11 latch |
| cfg_pol_i | input | 1 | Data inversion when 1 |
| cfg_dir_i | input | 1 | 1 selects the pad input, 0 selects the allocator input |
| cfg_clk_sel_i | input | 3 | Clock source code |
| cfg_init_sel_i | input | 1 | Clear source: 0 shared term, 1 individual term |
| alloc_i | input | 1 | Allocator data |
| io_i | input | 1 | Direct pad data |
| blk_clk_i | input | 4 | Block clocks |
| shr_clk_i | input | 1 | Shared term clock |
| ind_clk_i | input | 1 | Individual term clock |
| ce_i | input | 1 | Clock enable |
| shr_init_i | input | 1 | Shared initialization (clear) term |
| ind_init_i | input | 1 | Individual initialization (clear) term |
| preset_i | input | 1 | Preset term |
| q_o | output | 1 | Cell output |

## Verification
A pseudo-random sweep runs every mode at both polarities and with all eight clock codes. On each cycle it scrambles all block clocks, term clocks, data inputs, the enable, the clear terms and the preset. This separates load from toggle from latch behaviour, and a wrong clock-source code shows up as an edge at the wrong time. Directed sequences then hold one clock at a high level to tell a level trigger from an edge trigger. They also assert clear and preset together to show which one wins. Finally they drive only the unselected clear term and only the unselected data source to show that each is ignored.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_D     = 2'b01,
    MODE_T     = 2'b10,
    MODE_LATCH = 2'b11
  } mc_mode_e;
endpackage

// File: rtl/mc_data_path.sv
module mc_data_path (
  input  logic alloc_i,
  input  logic io_i,
  input  logic dir_i,
  input  logic pol_i,
  output logic d_o
);
  logic raw;
  assign raw = dir_i ? io_i : alloc_i;
  assign d_o = raw ^ pol_i;
endmodule

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int unsigned NUM_BLK_CLK = 4,
  localparam int unsigned NSRC  = NUM_BLK_CLK + 4,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
  input  logic                   shr_clk_i,
  input  logic                   ind_clk_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic                   lvl_o,
  output logic                   rise_o
);
  logic [NSRC-1:0] src;
  logic            prev_q;

  for (genvar i = 0; i < NUM_BLK_CLK; i++) begin : g_blk
    assign src[i] = blk_clk_i[i];
  end
  assign src[NUM_BLK_CLK]   = shr_clk_i;
  assign src[NUM_BLK_CLK+1] = ind_clk_i;
  assign src[NUM_BLK_CLK+2] = ~ind_clk_i;
  assign src[NUM_BLK_CLK+3] = ~shr_clk_i;

  // codes beyond the source count read as 0
  assign lvl_o  = (32'(sel_i) < NSRC) ? src[sel_i] : 1'b0;
  assign rise_o = lvl_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;
  end
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mcell_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mc_mode_e mode_i,
  input  logic     d_i,
  input  logic     lvl_i,
  input  logic     rise_i,
  input  logic     ce_i,
  input  logic     clr_i,
  input  logic     set_i,
  output logic     q_o
);
  logic state_q;
  logic open_w;

  assign open_w = lvl_i & ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= 1'b0;
    else if (clr_i)  state_q <= 1'b0;
    else if (set_i)  state_q <= 1'b1;
    else begin
      unique case (mode_i)
        MODE_D:     if (rise_i && ce_i) state_q <= d_i;
        MODE_T:     if (rise_i && ce_i && d_i) state_q <= ~state_q;
        MODE_LATCH: if (open_w) state_q <= d_i;
        default:    state_q <= state_q;
      endcase
    end
  end

  always_comb begin
    if (mode_i == MODE_COMB)                      q_o = d_i;
    else if (clr_i)                               q_o = 1'b0;
    else if (set_i)                               q_o = 1'b1;
    else if (mode_i == MODE_LATCH && open_w)      q_o = d_i;
    else                                          q_o = state_q;
  end
endmodule

// File: rtl/macrocell_cell.sv
module macrocell_cell
  import mcell_pkg::*;
#(
  parameter int unsigned NUM_BLK_CLK = 4,
  localparam int unsigned SEL_W = $clog2(NUM_BLK_CLK + 4)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             cfg_mode_i,
  input  logic                   cfg_pol_i,
  input  logic                   cfg_dir_i,
  input  logic [SEL_W-1:0]       cfg_clk_sel_i,
  input  logic                   cfg_init_sel_i,
  input  logic                   alloc_i,
  input  logic                   io_i,
  input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
  input  logic                   shr_clk_i,
  input  logic                   ind_clk_i,
  input  logic                   ce_i,
  input  logic                   shr_init_i,
  input  logic                   ind_init_i,
  input  logic                   preset_i,
  output logic                   q_o
);
  logic d_w, clk_lvl, clk_rise, clr_w;

  assign clr_w = cfg_init_sel_i ? ind_init_i : shr_init_i;

  mc_data_path i_data (
    .alloc_i (alloc_i),
    .io_i    (io_i),
    .dir_i   (cfg_dir_i),
    .pol_i   (cfg_pol_i),
    .d_o     (d_w)
  );

  mc_clk_sel #(.NUM_BLK_CLK(NUM_BLK_CLK)) i_clk_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blk_clk_i (blk_clk_i),
    .shr_clk_i (shr_clk_i),
    .ind_clk_i (ind_clk_i),
    .sel_i     (cfg_clk_sel_i),
    .lvl_o     (clk_lvl),
    .rise_o    (clk_rise)
  );

  mc_store i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mc_mode_e'(cfg_mode_i)),
    .d_i    (d_w),
    .lvl_i  (clk_lvl),
    .rise_i (clk_rise),
    .ce_i   (ce_i),
    .clr_i  (clr_w),
    .set_i  (preset_i),
    .q_o    (q_o)
  );
endmodule

// File: rtl/macrocell_cell_chk.sv
module macrocell_cell_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cfg_mode_i,
  input logic       cfg_pol_i,
  input logic       cfg_dir_i,
  input logic       cfg_init_sel_i,
  input logic       alloc_i,
  input logic       io_i,
  input logic       ce_i,
  input logic       shr_init_i,
  input logic       ind_init_i,
  input logic       preset_i,
  input logic       q_o,
  input logic       rise_i
);
  logic dat, clr, ovr;
  assign dat = (cfg_dir_i ? io_i : alloc_i) ^ cfg_pol_i;
  assign clr = cfg_init_sel_i ? ind_init_i : shr_init_i;
  assign ovr = clr | preset_i;

  p_comb_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'b00) |-> (q_o == dat));

  p_clear_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i != 2'b00 && clr) |-> (q_o == 1'b0));

  p_preset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i != 2'b00 && !clr && preset_i) |-> (q_o == 1'b1));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'b01 && rise_i && ce_i && !ovr) |=>
      (ovr || cfg_mode_i != 2'b01 || q_o == $past(dat)));

  p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'b10 && rise_i && ce_i && dat && !ovr) |=>
      (ovr || cfg_mode_i != 2'b10 || q_o != $past(q_o)));

  p_ce_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_mode_i == 2'b01 || cfg_mode_i == 2'b10) && !ce_i && !ovr) |=>
      (ovr || cfg_mode_i != $past(cfg_mode_i) || q_o == $past(q_o)));
endmodule

bind macrocell_cell macrocell_cell_chk i_chk (.*, .rise_i(clk_rise));

// File: tb/test_macrocell_cell.sv
module test_macrocell_cell;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cfg_mode_i = 2'b00;
  logic       cfg_pol_i = 1'b0, cfg_dir_i = 1'b0, cfg_init_sel_i = 1'b0;
  logic [2:0] cfg_clk_sel_i = 3'd0;
  logic       alloc_i = 1'b0, io_i = 1'b0;
  logic [3:0] blk_clk_i = 4'd0;
  logic       shr_clk_i = 1'b0, ind_clk_i = 1'b0, ce_i = 1'b0;
  logic       shr_init_i = 1'b0, ind_init_i = 1'b0, preset_i = 1'b0;
  logic       q_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic st = 1'b0, pm = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk_i = ~clk_i;

  macrocell_cell i_macrocell_cell (.*);

  task automatic check(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: q_o=%0b expected %0b (mode=%0d sel=%0d)", tag, got, exp, cfg_mode_i, cfg_clk_sel_i);
    end
  endtask

  function automatic logic src_lvl();
    case (cfg_clk_sel_i)
      3'd0, 3'd1, 3'd2, 3'd3: return blk_clk_i[cfg_clk_sel_i[1:0]];
      3'd4: return shr_clk_i;
      3'd5: return ind_clk_i;
      3'd6: return ~ind_clk_i;
      default: return ~shr_clk_i;
    endcase
  endfunction

  function automatic logic dval();
    return (cfg_dir_i ? io_i : alloc_i) ^ cfg_pol_i;
  endfunction

  function automatic logic clrv();
    return cfg_init_sel_i ? ind_init_i : shr_init_i;
  endfunction

  function automatic logic expect_q();
    if (cfg_mode_i == 2'b00) return dval();
    if (clrv()) return 1'b0;
    if (preset_i) return 1'b1;
    if (cfg_mode_i == 2'b11 && src_lvl() && ce_i) return dval();
    return st;
  endfunction

  // one cycle: check before the edge, update model, check after the edge
  task automatic cycle(input string tag);
    logic m, e;
    #1;
    check(tag, q_o, expect_q());
    m = src_lvl();
    e = m & ~pm;
    if (clrv()) st = 1'b0;
    else if (preset_i) st = 1'b1;
    else case (cfg_mode_i)
      2'b01: if (e && ce_i) st = dval();
      2'b10: if (e && ce_i && dval()) st = ~st;
      2'b11: if (m && ce_i) st = dval();
      default: ;
    endcase
    pm = m;
    @(posedge clk_i); #1;
    check(tag, q_o, expect_q());
  endtask

  task automatic quiet();
    blk_clk_i = 0; shr_clk_i = 0; ind_clk_i = 0; alloc_i = 0; io_i = 0;
    shr_init_i = 0; ind_init_i = 0; preset_i = 0; ce_i = 1;
  endtask

  function automatic string mode_tag();
    case (cfg_mode_i)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    quiet();
    cfg_mode_i = 2'b01;
    repeat (3) @(posedge clk_i);
    #1; check("R1", q_o, 1'b0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    pm = 1'b0; st = 1'b0;
    check("R1", q_o, 1'b0);

    // R6: each code, pulse only the intended source
    for (int s = 0; s < 8; s++) begin
      cfg_clk_sel_i = 3'(s);
      quiet();
      shr_clk_i = (s == 7); ind_clk_i = (s == 6);
      cycle("R6");
      alloc_i = 1'b1;
      if (s < 4) blk_clk_i[s] = 1'b1;
      else if (s == 4) shr_clk_i = 1'b1;
      else if (s == 5) ind_clk_i = 1'b1;
      else if (s == 6) ind_clk_i = 1'b0;
      else shr_clk_i = 1'b0;
      cycle("R6");
      check("R6", q_o, 1'b1);
      preset_i = 0; shr_init_i = 1; cycle("R8");
    end

    // R7: level held high with changing data, then edges with enable low
    quiet(); cfg_clk_sel_i = 3'd0; cfg_mode_i = 2'b01;
    cycle("R7");
    blk_clk_i[0] = 1; alloc_i = 1; cycle("R7");
    for (int k = 0; k < 4; k++) begin alloc_i = k[0]; cycle("R7"); end
    check("R7", q_o, 1'b1);
    ce_i = 0;
    for (int k = 0; k < 6; k++) begin blk_clk_i[0] = k[0]; alloc_i = 0; cycle("R7"); end
    check("R7", q_o, 1'b1);

    // R8 / R9 / R10 priorities and source selection
    quiet(); cfg_init_sel_i = 0; shr_init_i = 1; preset_i = 1; cycle("R8");
    quiet(); preset_i = 1; cycle("R9");
    quiet(); cfg_init_sel_i = 1; shr_init_i = 1; cycle("R10");
    check("R10", q_o, 1'b1);
    ind_init_i = 1; shr_init_i = 0; cycle("R10");
    quiet(); cfg_init_sel_i = 0; preset_i = 1; cycle("R9");
    quiet(); ind_init_i = 1; cycle("R10");
    check("R10", q_o, 1'b1);

    // R11 data source selection
    quiet(); cfg_mode_i = 2'b00; cfg_dir_i = 1; io_i = 1; alloc_i = 0; cycle("R11");
    io_i = 0; alloc_i = 1; cycle("R11");
    cfg_dir_i = 0; cycle("R11");

    // R2: clear and preset do not touch the combinational path
    shr_init_i = 1; preset_i = 1; alloc_i = 1; cycle("R2");
    alloc_i = 0; cycle("R2");

    // near-exhaustive sweep over mode, polarity, clock code
    for (int md = 0; md < 4; md++)
      for (int pl = 0; pl < 2; pl++)
        for (int s = 0; s < 8; s++) begin
          cfg_mode_i = 2'(md); cfg_pol_i = pl[0]; cfg_clk_sel_i = 3'(s);
          for (int c = 0; c < 100; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            blk_clk_i = lf[3:0]; shr_clk_i = lf[4]; ind_clk_i = lf[5];
            alloc_i = lf[6]; io_i = lf[7]; ce_i = lf[8] | lf[9];
            cfg_dir_i = lf[14]; cfg_init_sel_i = lf[1] ^ lf[9];
            shr_init_i = (lf[12:10] == 3'd0); ind_init_i = (lf[15:13] == 3'd0);
            preset_i = lf[11] & lf[12] & lf[13];
            cycle(mode_tag());
          end
        end

    // R1: asynchronous clear mid-run
    quiet(); cfg_mode_i = 2'b01; cfg_pol_i = 0; preset_i = 1; cycle("R9");
    preset_i = 0;
    #2 rst_ni = 1'b0;
    #1 check("R1", q_o, 1'b0);
    st = 1'b0; pm = 1'b0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    cycle("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule